// File: doc/BRIEF.md
# Weighted-Accumulator Serial Byte Receiver

This block receives one byte from a serial data line without using a shift register. A single start pulse begins a capture. The block then drives its own serial clock, with eight pulses of four system clocks each, and samples the data line through one register. For every bit, a binary weight is added into an 11-bit accumulator. The weight starts at the top bit position and halves after each bit period, so a high bit lands at its correct binary place. A high bit is counted more than once, so a fixed right shift at the end removes the repeated counts. The block then presents the corrected byte together with a one-clock done strobe.

There are two counting modes. In level mode the weight is added on every clock in which the sampled line is high, which gives four counts per bit and a shift of two. In edge mode the weight is added only where the product of the serial clock and the sampled line rises. This counts once per bit with twice the weight, then shifts right by one. Edge mode ignores the line during the clocks in which the serial clock is low, which is when the transmitter is expected to change it.

The output has no ready input and cannot apply back-pressure. The byte is valid in the cycle in which done is high. It stays on the data output until the next capture completes, so a consumer may also pick it up later. A start pulse is only taken while the block is idle.

Top module: `wacc_serial_rx`

## Requirements
- R1: After reset, sck, done and data are all zero.
- R2: A start pulse seen while idle at a rising clock edge (call it edge 0) begins a capture. That edge clears the accumulator, loads the weight with the top bit (0x80) and latches edge_mode. The bits arrive MSB first: bit 7-k of the byte is taken from sdi as sampled at edges 4k to 4k+3.
- R3: sck is low while idle. During a capture it is high in the two cycles that follow edges 4k+1 and 4k+2, for k = 0 to 7, which gives 16 high cycles. Its first high cycle comes one cycle after the accumulator is enabled.
- R4: Level mode (edge_mode = 0): the weight is added on every clock with the sampled line high. The result is the accumulator shifted right by two and equals the received byte.
- R5: Edge mode (edge_mode = 1): twice the weight is added once per rising edge of (sck AND sampled sdi). The result is the accumulator shifted right by one and equals the received byte.
- R6: In edge mode, sdi values sampled at edges 4k and 4k+3, while sck is low, do not change the result.
- R7: The weight halves once per four-clock bit period for exactly eight periods. done is high for exactly one cycle, the cycle after edge 33.
- R8: A start pulse during a busy capture is ignored. Neither the result nor the done timing changes.
- R9: A byte of 0xFF comes back as 0xFF in both modes. The 11-bit accumulator never carries out.
- R10: data holds its value after done falls, until the next capture completes.
- R11: A change of edge_mode during a capture has no effect on that capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture request pulse, taken only when idle |
| edge_mode | input | 1 | 0 = level counting, 1 = edge counting; latched at start |
| sdi | input | 1 | Serial data line |
| sck | output | 1 | Generated serial clock |
| data | output | 8 | Received byte |
| done | output | 1 | One-cycle strobe: data is valid |

## Verification
On every cycle, the in-RTL assertions check the following: the weight stays one-hot while a capture runs, the weight is not reloaded by a start pulse while busy, sck stays low when idle, sck pulses are at least two cycles wide, the accumulator never carries out, and done lasts a single cycle. Only the bench's scenarios can show that the recovered byte equals the transmitted one in each mode. The same holds for the exact cycle placement of the sck pulses and of done, for the immunity to sdi changes while sck is low in edge mode, and for the ignored mid-capture start and mode changes. The bench also shows that the byte is held after done falls.

// File: rtl/wacc_pkg.sv
package wacc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } wacc_state_e;

  typedef enum logic {
    CNT_LEVEL = 1'b0,
    CNT_EDGE  = 1'b1
  } wacc_mode_e;
endpackage

// File: rtl/wacc_bit_timer.sv
module wacc_bit_timer #(
  parameter int DATA_W  = 8,
  parameter int PER_BIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic sck,
  output logic bit_end,
  output logic frame_end
);
  localparam int PH_W  = (PER_BIT > 1) ? $clog2(PER_BIT) : 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int HIGH_CLKS = PER_BIT / 2;
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PER_BIT - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  logic [PH_W-1:0]  ph;
  logic [BIT_W-1:0] bitn;

  assign bit_end   = run && (ph == PH_LAST);
  assign frame_end = bit_end && (bitn == BIT_LAST);

  // sck is registered: it rises one clock after the accumulator is enabled
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= '0;
      bitn <= '0;
      sck  <= 1'b0;
    end else begin
      sck <= run && (ph < PH_W'(HIGH_CLKS));
      if (load) begin
        ph   <= '0;
        bitn <= '0;
      end else if (run) begin
        if (ph == PH_LAST) begin
          ph   <= '0;
          bitn <= bitn + 1'b1;
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

  a_r3_sck_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> !sck);

  a_r3_sck_two_wide: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |=> sck);

  a_r7_bit_index_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bit_end && !load) |=> (bitn == $past(bitn)));
endmodule

// File: rtl/wacc_weight.sv
module wacc_weight #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              active,
  output logic [DATA_W-1:0] weight
);
  localparam logic [DATA_W-1:0] W_INIT = DATA_W'(1) << (DATA_W - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)     weight <= '0;
    else if (load)  weight <= W_INIT;
    else if (step)  weight <= weight >> 1;
  end

  a_r7_weight_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ($countones(weight) == 1));

  a_r2_load_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> weight[DATA_W-1]);
endmodule

// File: rtl/wacc_accum.sv
module wacc_accum #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic              edge_mode,
  input  logic              sdi,
  input  logic              sck,
  input  logic [DATA_W-1:0] weight,
  output logic [ACC_W-1:0]  acc
);
  logic             sdi_q;
  logic             gate_q;
  logic             gate;
  logic             hit;
  logic [ACC_W-1:0] inc;
  logic [ACC_W:0]   sum;

  assign gate = sck & sdi_q;
  assign hit  = run && (edge_mode ? (gate && !gate_q) : sdi_q);
  assign inc  = edge_mode ? ACC_W'({weight, 1'b0}) : ACC_W'(weight);
  assign sum  = {1'b0, acc} + {1'b0, inc};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sdi_q  <= 1'b0;
      gate_q <= 1'b0;
      acc    <= '0;
    end else begin
      sdi_q  <= sdi;
      gate_q <= gate;
      if (clear)    acc <= '0;
      else if (hit) acc <= sum[ACC_W-1:0];
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !sum[ACC_W]);

  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc == '0));
endmodule

// File: rtl/wacc_serial_rx.sv
module wacc_serial_rx #(
  parameter int DATA_W  = 8,
  parameter int PER_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              edge_mode,
  input  logic              sdi,
  output logic              sck,
  output logic [DATA_W-1:0] data,
  output logic              done
);
  import wacc_pkg::*;

  localparam int LVL_SHIFT = $clog2(PER_BIT);
  localparam int ACC_W     = DATA_W + LVL_SHIFT + 1;

  wacc_state_e       state;
  wacc_mode_e        mode_q;
  logic              accept;
  logic              run;
  logic              bit_end;
  logic              frame_end;
  logic [DATA_W-1:0] weight;
  logic [ACC_W-1:0]  acc;

  assign accept = (state == ST_IDLE) && start;
  assign run    = (state == ST_RUN);

  wacc_bit_timer #(.DATA_W(DATA_W), .PER_BIT(PER_BIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(accept), .run(run),
    .sck(sck), .bit_end(bit_end), .frame_end(frame_end)
  );

  wacc_weight #(.DATA_W(DATA_W)) u_weight (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(bit_end),
    .active(run), .weight(weight)
  );

  wacc_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .clear(accept), .run(run),
    .edge_mode(mode_q == CNT_EDGE), .sdi(sdi), .sck(sck),
    .weight(weight), .acc(acc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_q <= CNT_LEVEL;
      data   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state  <= ST_RUN;
          mode_q <= edge_mode ? CNT_EDGE : CNT_LEVEL;
        end
        ST_RUN:  if (frame_end) state <= ST_FIN;
        ST_FIN: begin
          state <= ST_IDLE;
          done  <= 1'b1;
          data  <= (mode_q == CNT_EDGE) ? acc[1 +: DATA_W] : acc[LVL_SHIFT +: DATA_W];
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_busy_start_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && !bit_end) |=> (weight == $past(weight)));

  a_r11_mode_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> (mode_q == $past(mode_q)));

  a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && $past(state) != ST_FIN) |-> $stable(data));
endmodule

// File: tb/wacc_serial_rx_test.sv
`timescale 1ns/1ps
module wacc_serial_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       edge_mode = 1'b0;
  logic       sdi = 1'b0;
  logic       sck;
  logic [7:0] data;
  logic       done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wacc_serial_rx uut (
    .clk(clk), .rst_n(rst_n), .start(start), .edge_mode(edge_mode),
    .sdi(sdi), .sck(sck), .data(data), .done(done)
  );

  // {mode, glitch, byte}
  localparam logic [9:0] VECS [8] = '{
    {1'b0, 1'b0, 8'hA5}, {1'b0, 1'b0, 8'h3C}, {1'b0, 1'b0, 8'hFF}, {1'b0, 1'b0, 8'h00},
    {1'b1, 1'b0, 8'hA5}, {1'b1, 1'b0, 8'hFF}, {1'b1, 1'b1, 8'h81}, {1'b1, 1'b1, 8'h5A}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic line_val(input logic [7:0] b, input bit glitch, input int j);
    logic v;
    if (j >= 32) return 1'b0;
    v = b[7 - j / 4];
    if (glitch && (j % 4 == 0 || j % 4 == 3)) v = ~v;
    return v;
  endfunction

  // One capture; cycle i is the cycle after edge i (edge 0 accepts start)
  task automatic capture(input logic [7:0] b, input bit mode, input bit glitch,
                         input bit mid_start, input bit flip_mode, input string req);
    int sck_bad = 0;
    int sck_high = 0;
    int done_at = -1;
    int done_cnt = 0;
    @(negedge clk);
    start = 1'b1;
    edge_mode = mode;
    sdi = line_val(b, glitch, 0);
    for (int i = 0; i <= 40; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (sck) sck_high++;
      if (sck !== ((i < 32) && (i % 4 == 1 || i % 4 == 2))) sck_bad++;
      if (done) begin done_cnt++; done_at = i; end
      if (i == 33) chk(data == b, {req, " data"}, data, b);
      start = (mid_start && i == 10);
      if (flip_mode && i == 5) edge_mode = ~mode;
      sdi = line_val(b, glitch, i + 1);
    end
    chk(sck_bad == 0 && sck_high == 16, "R3 sck pattern", sck_high, 16);
    chk(done_cnt == 1 && done_at == 33, "R7 done timing", done_at, 33);
    chk(data == b, "R10 data held", data, b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sck == 1'b0, "R1 sck", sck, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(data == 8'h00, "R1 data", data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sck == 1'b0, "R3 sck idle", sck, 0);

    for (int v = 0; v < 8; v++) begin
      logic [9:0] e;
      e = VECS[v];
      // R2 MSB-first; R4 level, R5 edge, R6 glitch, R9 0xFF
      capture(e[7:0], e[9], e[8], 1'b0, 1'b0,
              e[9] ? (e[8] ? "R6 R5 edge glitch" : "R5 R9 edge") : "R2 R4 R9 level");
    end

    capture(8'h96, 1'b0, 1'b0, 1'b1, 1'b0, "R8 busy start");
    capture(8'hC3, 1'b0, 1'b0, 1'b0, 1'b1, "R11 mode change level");
    capture(8'h6E, 1'b1, 1'b0, 1'b0, 1'b1, "R11 mode change edge");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule